// File: doc/BRIEF.md
# External Bus Strobe Generator

This block sits beside a small controller core. It turns the oscillator clock into the timing of the external memory bus. A free-running counter splits every machine cycle of twelve oscillator clocks into six states, S1 to S6, each with two phases, P1 and P2. From that counter the block drives two signals:

- an address-latch-enable pulse (`ale`), which normally runs at one sixth of the clock rate;
- an active-low program-store read strobe (`psen_n`), which is used while code is fetched from external memory.

The sequencer announces each machine cycle before it starts, using two flags:

- `xdata_cyc`: the coming cycle moves data to or from external memory. The block then drops the second address pulse and both program strobes of that cycle.
- `ctab_rd`: the coming cycle reads a code table.

A register bit `ale_off` can silence the address pulse outside such accesses, unless the part is strapped for external execution. The `phase_idx` output tells other logic where the cycle stands.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `phase_idx` is 0, `ale` is low and `psen_n` is high.
- R2: `phase_idx` counts 0 to 11 and wraps, one step per clock. The value equals 2*(state-1)+(phase-1), so S1P1=0, S2P1=2, S3P1=4, S4P1=6, S5P1=8 and S6P1=10. The first rising edge after reset moves it from 0 to 1.
- R3: In a normal cycle, `ale` is high at indices 1, 2, 7 and 8, which gives two pulses per machine cycle.
- R4: With `ext_exec` high in a cycle without a data access, `psen_n` is low at indices 4, 5, 6, 10 and 11, and at index 0 of the following cycle.
- R5: With `ext_exec` low, `psen_n` stays high, apart from the index-0 tail owed by a preceding externally executed cycle.
- R6: In a cycle flagged by `xdata_cyc`, `ale` is low at indices 7 and 8. `psen_n` is high throughout that cycle and at index 0 of the next cycle. The pulse at indices 1 and 2 remains.
- R7: `xdata_cyc` and `ctab_rd` are sampled at the rising edge that ends index 11. They apply to the whole machine cycle that follows, and values at other edges have no effect.
- R8: With `ale_off` high, `ext_exec` low and neither access flag latched, `ale` stays low for the whole cycle.
- R9: With `ale_off` high, a latched `ctab_rd` gives both `ale` pulses, and a latched `xdata_cyc` gives the first pulse only.
- R10: With `ext_exec` high, `ale_off` has no effect on `ale`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xdata_cyc | input | 1 | Coming cycle accesses external data memory |
| ctab_rd | input | 1 | Coming cycle reads a code table |
| ext_exec | input | 1 | Strap: code is executed from external memory |
| ale_off | input | 1 | Register bit that suppresses `ale` outside accesses |
| ale | output | 1 | Address latch enable pulse |
| psen_n | output | 1 | Active-low program-store read strobe |
| phase_idx | output | 4 | Position within the machine cycle, 0 to 11 |

## Verification
The case that is hardest to reach is the strobe tail at index 0. It belongs to the cycle before, so its expected value depends on two machine cycles at once. The cases that expose it are a data cycle placed right after an executed cycle, and the cycle that follows the data cycle. The stimulus waits until the bench's own cycle position reaches index 11, then changes the flags on the falling edge, so every scenario starts exactly on a cycle boundary. Cycle kinds are chained back to back: normal, data, normal, table read, and a switch of the execution strap.

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xdata_cyc,
  input  logic       ctab_rd,
  input  logic       ext_exec,
  input  logic       ale_off,
  output logic       ale,
  output logic       psen_n,
  output logic [3:0] phase_idx
);

  localparam logic [3:0] LAST = 4'd11;

  logic [3:0] idx;
  logic       dcyc, tcyc, tail;
  logic       wrap;

  assign wrap = (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      dcyc <= 1'b0;
      tcyc <= 1'b0;
      tail <= 1'b0;
    end else begin
      idx <= wrap ? '0 : idx + 4'd1;
      if (wrap) begin
        dcyc <= xdata_cyc;
        tcyc <= ctab_rd;
        tail <= ext_exec & ~dcyc;
      end
    end
  end

  logic win_a1, win_a2, win_p1, win_p2, ale_en, strobe_on;

  assign win_a1    = (idx == 4'd1) | (idx == 4'd2);
  assign win_a2    = (idx == 4'd7) | (idx == 4'd8);
  assign win_p1    = (idx >= 4'd4) & (idx <= 4'd6);
  assign win_p2    = (idx == 4'd10) | (idx == 4'd11);
  assign ale_en    = ext_exec | ~ale_off | dcyc | tcyc;
  assign strobe_on = ext_exec & ~dcyc;

  assign ale       = ale_en & (win_a1 | (win_a2 & ~dcyc));
  assign psen_n    = ~((strobe_on & (win_p1 | win_p2)) | ((idx == 4'd0) & tail));
  assign phase_idx = idx;

  // R2
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_idx == LAST) |=> (phase_idx == 4'd0));

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_idx < LAST) |=> (phase_idx == $past(phase_idx) + 4'd1));

  // R3
  ale_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> (phase_idx == 4'd1 || phase_idx == 4'd7));

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && !psen_n));

  // R5
  int_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_exec && phase_idx != 4'd0) |-> psen_n);

  // R6
  data_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dcyc && phase_idx != 4'd0) |-> (psen_n && !(phase_idx == 4'd7 && ale)));

endmodule

// File: tb/sim_bus_strobe_gen.sv
module sim_bus_strobe_gen;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xdata_cyc = 1'b0, ctab_rd = 1'b0, ext_exec = 1'b0, ale_off = 1'b0;
  logic ale, psen_n;
  logic [3:0] phase_idx;

  int checks = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  bus_strobe_gen u0 (
    .clk(clk), .rst_n(rst_n), .xdata_cyc(xdata_cyc), .ctab_rd(ctab_rd),
    .ext_exec(ext_exec), .ale_off(ale_off), .ale(ale), .psen_n(psen_n),
    .phase_idx(phase_idx)
  );

  int kb = 0;
  bit md = 0, mt = 0, mtail = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kb <= 0; md <= 0; mt <= 0; mtail <= 0;
    end else begin
      if (kb == 11) begin
        md <= xdata_cyc;
        mt <= ctab_rd;
        mtail <= ext_exec && !md;
      end
      kb <= (kb == 11) ? 0 : kb + 1;
    end
  end

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at t=%0t idx=%0d: actual %0d expected %0d", req, $time, kb, act, exp);
    end
  endtask

  task automatic tick(string ale_req, string psen_req);
    bit ea, ep;
    @(negedge clk);
    ea = (ext_exec || !ale_off || md || mt) &&
         ((kb == 1 || kb == 2) || ((kb == 7 || kb == 8) && !md));
    ep = !((ext_exec && !md && (kb == 4 || kb == 5 || kb == 6 || kb == 10 || kb == 11)) ||
           (kb == 0 && mtail));
    check("R2", phase_idx, 4'(kb));
    check(ale_req, {3'b0, ale}, {3'b0, ea});
    check(psen_req, {3'b0, psen_n}, {3'b0, ep});
  endtask

  task automatic apply(bit ed, bit tr, bit ex, bit dis, int ncyc, string ar, string pr);
    while (kb != 11) tick(ar, pr);
    xdata_cyc = ed; ctab_rd = tr; ext_exec = ex; ale_off = dis;
    repeat (12 * ncyc) tick(ar, pr);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1", phase_idx, 4'd0);
    check("R1", {3'b0, ale}, 4'd0);
    check("R1", {3'b0, psen_n}, 4'd1);
    rst_n = 1'b1;
  endtask

  task automatic t_normal;
    apply(0, 0, 1, 0, 3, "R3", "R4");
  endtask

  task automatic t_internal;
    apply(0, 0, 0, 0, 2, "R3", "R5");
  endtask

  task automatic t_data;
    apply(0, 0, 1, 0, 1, "R3", "R4");
    apply(1, 0, 1, 0, 1, "R6", "R6");
    apply(0, 0, 1, 0, 1, "R6", "R6");
    while (kb != 5) tick("R7", "R7");
    xdata_cyc = 1'b1;
    repeat (3) tick("R7", "R7");
    xdata_cyc = 1'b0;
    repeat (12) tick("R7", "R7");
  endtask

  task automatic t_disable;
    apply(0, 0, 0, 1, 2, "R8", "R5");
  endtask

  task automatic t_table;
    apply(0, 1, 0, 1, 1, "R9", "R5");
    apply(1, 0, 0, 1, 1, "R9", "R5");
    apply(0, 0, 0, 1, 1, "R8", "R5");
  endtask

  task automatic t_override;
    apply(0, 0, 1, 1, 2, "R10", "R4");
    apply(1, 0, 1, 1, 1, "R10", "R6");
    apply(0, 0, 0, 1, 1, "R8", "R5");
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_internal();
    t_data();
    t_disable();
    t_table();
    t_override();
    t_normal();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule